// File: doc/BRIEF.md
# Coprocessor Register Transfer and Compare Unit

This unit sits beside a processor core and owns a bank of sixteen 64-bit registers. Each register is reached as two 32-bit halves. The core hands the unit one decoded transfer request per cycle. Each request carries a direction bit, a 32-bit instruction word and a 32-bit data value. A request in the core-to-unit direction writes one half of a register. A request in the unit-to-core direction returns one half of a register, or the result of a signed integer compare of two registers. The compare result is four condition flags packed into the top of a 32-bit word.

The instruction word holds three fields. Bits 7:5 carry the operation code. Bits 19:16 name the first source register, which is also the register a write targets. Bits 3:0 name the second source register. Bits 15:12 carry a destination field that no register transfer uses, and all remaining bits are ignored. Reads are combinational from the current register contents. Writes land on the next rising clock edge. An operation code that is not defined for the request's direction is reported on an error output.

The error output comes from a two-state machine. `ST_IDLE` is the normal state and `ST_FAULT` drives the error output. The machine moves from `ST_IDLE` to `ST_FAULT` on an undefined request. It stays in `ST_FAULT` while undefined requests keep arriving. It moves back to `ST_IDLE` on any cycle without an undefined request.

Top module: `cpx_xfer_unit`

## Requirements
- R1: After reset every half of every register reads as zero and `op_error` is low.
- R2: A valid write (`req_to_core`=0) with code 0 stores `req_wdata` into the lower half of the register named by bits 19:16 on the next clock edge and leaves its upper half unchanged.
- R3: A valid write with code 1 stores `req_wdata` into the upper half of that register on the next clock edge and leaves its lower half unchanged.
- R4: A valid write with code 2 (single-precision value) also stores `req_wdata` into the upper half, and the lower half is unchanged.
- R5: A valid read (`req_to_core`=1) returns on `rsp_rdata`, in the same cycle, the lower half of the register named by bits 19:16 for code 0 and its upper half for codes 1 and 2. `rsp_rdata` is zero when no valid read is present.
- R6: Read code 4 compares the lower halves of the first source (a) and the second source (b) as signed 32-bit values. Read code 5 compares whole 64-bit registers. The result word holds N in bit 31, Z in bit 30, C in bit 29 and V in bit 28, with bits 27:0 zero. Z is set when a-b is zero, and N is set when a-b is negative at the compare width.
- R7: C is set when (a negative and b non-negative), or (a negative and a-b non-negative), or (b non-negative and a-b non-negative). Signs are taken at the compare width.
- R8: V is set when a and b have opposite signs and the sign of a-b differs from the sign of a, at either compare width.
- R9: The 64-bit compare uses the upper halves. Two registers whose lower halves match but whose upper halves differ give Z=0 for code 5 and Z=1 for code 4.
- R10: A valid request with an undefined code (writes: 3 to 7; reads: 3, 6 and 7) raises `op_error` in the following cycle, for one cycle per such request. It changes no register, and an undefined read returns zero.
- R11: While `req_valid` is low, no register changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A transfer request is present this cycle |
| req_to_core | input | 1 | 1: unit-to-core read or compare; 0: core-to-unit write |
| req_instr | input | 32 | Instruction word: code in 7:5, first source in 19:16, second source in 3:0 |
| req_wdata | input | 32 | Data value for writes |
| rsp_rdata | output | 32 | Register half or packed compare flags |
| op_error | output | 1 | One-cycle report of an undefined operation code |

## Verification
The register half transfers are tried with random data written through all three write codes to every register, followed by reads of both halves. This pattern separates the half that was written from the half that must be left alone. The compares are run on equal operands, on the most positive value against the most negative one, on mixed signs near zero, and on register pairs whose lower halves match but whose upper halves differ. These cases pull N, C and V apart and show whether the 64-bit compare uses the upper halves. Many random compares then follow. Undefined codes are sent singly and back to back, and idle cycles carry garbage data. These patterns show the length of the error pulse and that no register state moves.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    typedef enum logic [2:0] {
        OPC_LOW    = 3'd0,
        OPC_HIGH   = 3'd1,
        OPC_SINGLE = 3'd2,
        OPC_CMP_W  = 3'd4,
        OPC_CMP_D  = 3'd5
    } opc_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FAULT = 1'b1
    } fault_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cmp_flags_t;

    localparam int OPC_LSB  = 5;
    localparam int OPC_W    = 3;
    localparam int SRCA_LSB = 16;
    localparam int SRCB_LSB = 0;

endpackage

// File: rtl/cpx_regfile.sv
module cpx_regfile #(
    parameter int NREGS  = 16,
    parameter int HALF_W = 32,
    localparam int AW    = $clog2(NREGS),
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [AW-1:0]     waddr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [FULL_W-1:0] rd_a,
    output logic [FULL_W-1:0] rd_b
);

    logic [NREGS-1:0][FULL_W-1:0] regs_q;

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (waddr == AW'(g)) begin
                if (we_lo) regs_q[g][HALF_W-1:0]      <= wdata;
                if (we_hi) regs_q[g][FULL_W-1:HALF_W] <= wdata;
            end
        end
    end

    assign rd_a = regs_q[raddr_a];
    assign rd_b = regs_q[raddr_b];

    // R2: lower-half write lands, upper half of that entry untouched
    assert_low_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo && !we_hi) |=> (regs_q[$past(waddr)][HALF_W-1:0] == $past(wdata))
            && (regs_q[$past(waddr)][FULL_W-1:HALF_W] == $past(regs_q[waddr][FULL_W-1:HALF_W])));

    // R3 / R4: upper-half write lands, lower half untouched
    assert_high_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && !we_lo) |=> (regs_q[$past(waddr)][FULL_W-1:HALF_W] == $past(wdata))
            && (regs_q[$past(waddr)][HALF_W-1:0] == $past(regs_q[waddr][HALF_W-1:0])));

    // R11 / R10: no enable, no change anywhere
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_lo && !we_hi) |=> $stable(regs_q));

endmodule

// File: rtl/cpx_compare.sv
module cpx_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    output cpx_pkg::cmp_flags_t  flags
);

    logic [W-1:0] diff;
    logic         sa, sb, sr;

    always_comb begin
        diff    = a - b;
        sa      = a[W-1];
        sb      = b[W-1];
        sr      = diff[W-1];
        flags.n = sr;
        flags.z = (diff == '0);
        flags.c = (sa && !sb) || (sa && !sr) || (!sb && !sr);
        flags.v = (sa != sb) && (sr != sa);
    end

endmodule

// File: rtl/cpx_xfer_unit.sv
module cpx_xfer_unit #(
    parameter int NREGS  = 16,
    parameter int HALF_W = 32,
    localparam int AW    = $clog2(NREGS),
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_to_core,
    input  logic [31:0]       req_instr,
    input  logic [HALF_W-1:0] req_wdata,
    output logic [HALF_W-1:0] rsp_rdata,
    output logic              op_error
);
    import cpx_pkg::*;

    logic [OPC_W-1:0]   opc;
    logic [AW-1:0]      src_a, src_b;
    logic               known_rd, known_wr, bad_req;
    logic               we_lo, we_hi;
    logic [FULL_W-1:0]  val_a, val_b;
    cmp_flags_t         flg_w, flg_d;
    fault_state_e       state_q, state_d;
    logic               unused_instr_bits;

    assign opc   = req_instr[OPC_LSB +: OPC_W];
    assign src_a = req_instr[SRCA_LSB +: AW];
    assign src_b = req_instr[SRCB_LSB +: AW];
    assign unused_instr_bits = ^{req_instr[31:SRCA_LSB+AW], req_instr[SRCA_LSB-1:OPC_LSB+OPC_W],
                                 req_instr[OPC_LSB-1:SRCB_LSB+AW]};

    always_comb begin
        known_rd = 1'b0;
        known_wr = 1'b0;
        unique case (opc)
            OPC_LOW, OPC_HIGH, OPC_SINGLE: begin known_rd = 1'b1; known_wr = 1'b1; end
            OPC_CMP_W, OPC_CMP_D:          known_rd = 1'b1;
            default:                       ;
        endcase
    end

    assign bad_req = req_valid && (req_to_core ? !known_rd : !known_wr);
    assign we_lo   = req_valid && !req_to_core && (opc == OPC_LOW);
    assign we_hi   = req_valid && !req_to_core && (opc == OPC_HIGH || opc == OPC_SINGLE);

    cpx_regfile #(.NREGS(NREGS), .HALF_W(HALF_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_lo   (we_lo),
        .we_hi   (we_hi),
        .waddr   (src_a),
        .wdata   (req_wdata),
        .raddr_a (src_a),
        .raddr_b (src_b),
        .rd_a    (val_a),
        .rd_b    (val_b)
    );

    cpx_compare #(.W(HALF_W)) u_cmp_word (
        .a     (val_a[HALF_W-1:0]),
        .b     (val_b[HALF_W-1:0]),
        .flags (flg_w)
    );

    cpx_compare #(.W(FULL_W)) u_cmp_dbl (
        .a     (val_a),
        .b     (val_b),
        .flags (flg_d)
    );

    // read / compare result path
    always_comb begin
        rsp_rdata = '0;
        if (req_valid && req_to_core) begin
            unique case (opc)
                OPC_LOW:              rsp_rdata = val_a[HALF_W-1:0];
                OPC_HIGH, OPC_SINGLE: rsp_rdata = val_a[FULL_W-1:HALF_W];
                OPC_CMP_W:            rsp_rdata = {flg_w, {(HALF_W-4){1'b0}}};
                OPC_CMP_D:            rsp_rdata = {flg_d, {(HALF_W-4){1'b0}}};
                default:              rsp_rdata = '0;
            endcase
        end
    end

    // fault state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // fault state machine: transitions and output
    always_comb begin
        state_d  = state_q;
        op_error = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bad_req) state_d = ST_FAULT;
            end
            ST_FAULT: begin
                op_error = 1'b1;
                state_d  = bad_req ? ST_FAULT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_err_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> op_error);

    assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_req |=> !op_error);

    assert_no_write_on_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |-> !(we_lo || we_hi));

    assert_cmp_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_to_core && opc == OPC_CMP_W) |->
            (rsp_rdata[HALF_W-2] == (val_a[HALF_W-1:0] == val_b[HALF_W-1:0]))
            && (rsp_rdata[HALF_W-5:0] == '0));

    assert_cmp_dbl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_to_core && opc == OPC_CMP_D) |->
            (rsp_rdata[HALF_W-2] == (val_a == val_b)));

endmodule

// File: tb/cpx_xfer_unit_bench.sv
`timescale 1ns/100ps
module cpx_xfer_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_to_core = 1'b0;
    logic [31:0] req_instr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        op_error;

    int checks = 0;
    int failures = 0;
    bit [63:0] mdl [16];
    bit exp_err = 1'b0;

    always #2 clk = ~clk;

    cpx_xfer_unit u_cpx_xfer_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_to_core(req_to_core),
        .req_instr(req_instr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .op_error(op_error)
    );

    function automatic bit [31:0] flags32(input bit [31:0] ua, input bit [31:0] ub);
        int a, b, r;
        bit an, bn, rn, n, z, c, v;
        a = int'(ua); b = int'(ub); r = a - b;
        an = a < 0; bn = b < 0; rn = r < 0;
        n = rn; z = (r == 0);
        c = (an && !bn) || (an && !rn) || (!bn && !rn);
        v = (an != bn) && (rn != an);
        return {n, z, c, v, 28'd0};
    endfunction

    function automatic bit [31:0] flags64(input bit [63:0] ua, input bit [63:0] ub);
        longint a, b, r;
        bit an, bn, rn, n, z, c, v;
        a = longint'(ua); b = longint'(ub); r = a - b;
        an = a < 0; bn = b < 0; rn = r < 0;
        n = rn; z = (r == 0);
        c = (an && !bn) || (an && !rn) || (!bn && !rn);
        v = (an != bn) && (rn != an);
        return {n, z, c, v, 28'd0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request per cycle; model compared every clock
    task automatic step(input bit v, input bit r, input int op, input int s1, input int s2,
                        input bit [31:0] d, input string tag);
        bit [31:0] er;
        bit bad;
        @(posedge clk); #0.5;
        req_valid   = v;
        req_to_core = r;
        req_instr   = {12'($urandom), 4'(s1), 4'($urandom), 4'd0, 3'(op), 1'b0, 4'(s2)};
        req_wdata   = d;
        er = 32'd0;
        if (v && r) begin
            case (op)
                0:       er = mdl[s1][31:0];
                1, 2:    er = mdl[s1][63:32];
                4:       er = flags32(mdl[s1][31:0], mdl[s2][31:0]);
                5:       er = flags64(mdl[s1], mdl[s2]);
                default: er = 32'd0;
            endcase
        end
        bad = v && (r ? !(op inside {0, 1, 2, 4, 5}) : !(op inside {0, 1, 2}));
        @(negedge clk);
        check({tag, " rdata"}, rsp_rdata, er);
        check({tag, " R10 err"}, {31'd0, op_error}, {31'd0, exp_err});
        exp_err = bad;
        if (v && !r) begin
            if (op == 0) mdl[s1][31:0] = d;
            else if (op == 1 || op == 2) mdl[s1][63:32] = d;
        end
    endtask

    task automatic set64(input int idx, input bit [63:0] val);
        step(1, 0, 0, idx, 0, val[31:0], "R2 setup");
        step(1, 0, 1, idx, 0, val[63:32], "R3 setup");
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        @(negedge clk);
        check("R1 err after reset", {31'd0, op_error}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            step(1, 1, 0, i, 0, 32'hFFFF_FFFF, "R1 low");
            step(1, 1, 1, i, 0, 32'hFFFF_FFFF, "R1 high");
        end
        // half writes via all three codes, then readback
        for (int i = 0; i < 16; i++) step(1, 0, 0, i, 0, $urandom, "R2 write low");
        for (int i = 0; i < 16; i++) step(1, 0, (i % 2) ? 2 : 1, i, 0, $urandom, "R3 R4 write high");
        for (int i = 0; i < 16; i++) begin
            step(1, 1, 0, i, 0, 0, "R5 read low");
            step(1, 1, 1, i, 0, 0, "R5 read high");
            step(1, 1, 2, i, 0, 0, "R5 read single");
        end
        step(1, 0, 2, 7, 0, 32'hCAFE_0002, "R4 single write");
        step(1, 1, 0, 7, 0, 0, "R4 lower kept");
        step(1, 1, 1, 7, 0, 0, "R4 upper");
        // idle cycles with garbage
        for (int i = 0; i < 8; i++) step(0, 0, i % 3, i, 0, $urandom, "R11 idle");
        step(0, 1, 0, 3, 0, 0, "R5 idle read zero");
        for (int i = 0; i < 16; i++) begin
            step(1, 1, 0, i, 0, 0, "R11 low kept");
            step(1, 1, 1, i, 0, 0, "R11 high kept");
        end
        // directed compares
        set64(1, 64'h0000_0000_0000_0005);
        set64(2, 64'h0000_0000_0000_0005);
        step(1, 1, 4, 1, 2, 0, "R6 cmp32 equal");
        step(1, 1, 5, 1, 2, 0, "R6 cmp64 equal");
        set64(3, 64'h0000_0000_7FFF_FFFF);
        set64(4, 64'hFFFF_FFFF_8000_0000);
        step(1, 1, 4, 3, 4, 0, "R8 cmp32 overflow");
        step(1, 1, 4, 4, 3, 0, "R8 cmp32 overflow rev");
        step(1, 1, 5, 3, 4, 0, "R7 cmp64 mixed");
        set64(5, 64'hFFFF_FFFF_FFFF_FFFF);
        set64(6, 64'h0000_0000_0000_0001);
        step(1, 1, 4, 5, 6, 0, "R7 cmp32 neg vs pos");
        step(1, 1, 4, 6, 5, 0, "R7 cmp32 pos vs neg");
        step(1, 1, 5, 5, 6, 0, "R7 cmp64 neg vs pos");
        set64(8, 64'h0000_0001_1234_5678);
        set64(9, 64'h0000_0000_1234_5678);
        step(1, 1, 4, 8, 9, 0, "R9 cmp32 lower equal");
        step(1, 1, 5, 8, 9, 0, "R9 cmp64 upper differs");
        set64(10, 64'h7FFF_FFFF_FFFF_FFFF);
        set64(11, 64'h8000_0000_0000_0000);
        step(1, 1, 5, 10, 11, 0, "R8 cmp64 overflow");
        step(1, 1, 5, 11, 10, 0, "R8 cmp64 overflow rev");
        step(1, 1, 5, 10, 10, 0, "R6 cmp64 self");
        // random compares
        for (int k = 0; k < 150; k++) begin
            step(1, 0, k % 2, k % 16, 0, ($urandom % 4 == 0) ? 32'h8000_0000 : $urandom, "R2 R3 rand fill");
            step(1, 1, 4, $urandom % 16, $urandom % 16, 0, "R6 R7 R8 rand cmp32");
            step(1, 1, 5, $urandom % 16, $urandom % 16, 0, "R7 R8 R9 rand cmp64");
        end
        // undefined codes
        for (int op = 3; op < 8; op++) step(1, 0, op, 12, 0, 32'hDEAD_0000 + op, "R10 bad write");
        step(0, 0, 0, 0, 0, 0, "R10 err clears");
        step(1, 1, 3, 12, 0, 0, "R10 bad read 3");
        step(0, 0, 0, 0, 0, 0, "R10 gap");
        step(1, 1, 6, 12, 0, 0, "R10 bad read 6");
        step(1, 1, 7, 12, 0, 0, "R10 bad read 7");
        step(1, 1, 0, 12, 0, 0, "R10 low kept");
        step(1, 1, 1, 12, 0, 0, "R10 high kept");
        step(0, 0, 0, 0, 0, 0, "R10 final");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule